// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 32-bit operands and an incoming carry and returns a 32-bit sum together with the carry leaving the top bit. It has no clock and no storage: the result follows the inputs through a fixed depth of logic. That depth does not grow with the distance a carry must travel.

The logic is arranged in four stages. A per-bit stage forms propagate (a XOR b) and generate (a AND b) for every bit. Eight 4-bit block units each reduce their four bit pairs to one group propagate and one group generate. A single second-level unit takes those eight group pairs and the incoming carry and forms the carry leaving every group. It does this in one flat sum-of-products, with no ripple from group to group. Each block unit then derives its three inner carries from its own incoming carry by lookahead. A summation stage XORs every propagate bit with the carry entering that bit. The carry leaving group 7 is the carry-out.

Top module: `cla32_adder`

## Requirements
- R1: `sum_o` equals the low 32 bits of `a_i + b_i + cin_i`, read as unsigned numbers.
- R2: `cout_o` equals bit 32 of `a_i + b_i + cin_i`, read as unsigned numbers.
- R3: When `a_i`, `b_i` and `cin_i` are all zero, `sum_o` is zero and `cout_o` is 0.
- R4: All-ones on `a_i` with `b_i` = 1 and `cin_i` = 0 gives `sum_o` = 0 and `cout_o` = 1.
- R5: With `a_i XOR b_i` all ones and `a_i AND b_i` zero, `cin_i` = 1 gives `sum_o` = 0 and `cout_o` = 1, and `cin_i` = 0 gives `sum_o` = all ones and `cout_o` = 0.
- R6: A carry generated in bit 0..3 (group 0) travels through groups 1 to 7 when all their bits propagate, and it reaches `cout_o`.
- R7: The alternating operands 0xAAAAAAAA and 0x55555555 give all ones with `cin_i` = 0, and give zero with `cout_o` = 1 when `cin_i` = 1.
- R8: The carry leaving group k (bits 4k..4k+3) is that group's generate OR (its propagate AND the carry entering it), where the carry entering group 0 is `cin_i`. Every 4-bit field of `sum_o` therefore equals the 4-bit sum of the matching operand fields plus the carry entering that group.
- R9: A group whose four bits all propagate never also generates, and it passes the carry entering it unchanged to the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| cout_o | output | 1 | Carry leaving bit 31 |

## Verification
Two carry functions settle for the same operands at the same moment. One is the second-level unit forming the group boundary carries. The other is each block unit forming its inner carries from the boundary carry it receives. The bench provokes both together with operands where a carry is generated low and must cross propagating groups, or must stop at a generating or killing group, including chains that run the full width. Each 4-bit field of the sum is judged against a nibble-wise arithmetic model in the bench, and the whole result against an unsigned 33-bit addition.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int MAX_SPAN = 32;

    // Carry leaving position top_idx of a span, as a flat sum of products.
    function automatic logic lookahead_carry(input logic [MAX_SPAN-1:0] p,
                                             input logic [MAX_SPAN-1:0] g,
                                             input logic cin,
                                             input int top_idx);
        logic acc;
        logic chain;
        acc = 1'b0;
        for (int j = 0; j < MAX_SPAN; j++) begin
            if (j <= top_idx) begin
                chain = g[j];
                for (int m = 0; m < MAX_SPAN; m++) begin
                    if (m > j && m <= top_idx) chain = chain & p[m];
                end
                acc = acc | chain;
            end
        end
        chain = cin;
        for (int m = 0; m < MAX_SPAN; m++) begin
            if (m <= top_idx) chain = chain & p[m];
        end
        acc = acc | chain;
        return acc;
    endfunction
endpackage

// File: rtl/cla_pg_stage.sv
module cla_pg_stage #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] gen_o
);
    always_comb begin
        prop_o = a_i ^ b_i;
        gen_o  = a_i & b_i;
    end
endmodule

// File: rtl/cla_block_unit.sv
module cla_block_unit
    import cla_pkg::*;
#(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] prop_i,
    input  logic [GRP-1:0] gen_i,
    input  logic           cin_i,
    output logic           grp_p_o,
    output logic           grp_g_o,
    output logic [GRP-1:0] bit_c_o
);
    logic [MAX_SPAN-1:0] p_ext;
    logic [MAX_SPAN-1:0] g_ext;

    always_comb begin
        p_ext = '0;
        g_ext = '0;
        p_ext[GRP-1:0] = prop_i;
        g_ext[GRP-1:0] = gen_i;
        grp_p_o = &prop_i;
        grp_g_o = lookahead_carry(p_ext, g_ext, 1'b0, GRP - 1);
        bit_c_o[0] = cin_i;
        for (int i = 1; i < GRP; i++) begin
            bit_c_o[i] = lookahead_carry(p_ext, g_ext, cin_i, i - 1);
        end
    end
endmodule

// File: rtl/cla_group_unit.sv
module cla_group_unit
    import cla_pkg::*;
#(
    parameter int NGRP = 8
) (
    input  logic [NGRP-1:0] grp_p_i,
    input  logic [NGRP-1:0] grp_g_i,
    input  logic            cin_i,
    output logic [NGRP-1:0] blk_c_o
);
    logic [MAX_SPAN-1:0] p_ext;
    logic [MAX_SPAN-1:0] g_ext;

    always_comb begin
        p_ext = '0;
        g_ext = '0;
        p_ext[NGRP-1:0] = grp_p_i;
        g_ext[NGRP-1:0] = grp_g_i;
        for (int k = 0; k < NGRP; k++) begin
            blk_c_o[k] = lookahead_carry(p_ext, g_ext, cin_i, k);
        end
    end
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] bit_c_i,
    output logic [WIDTH-1:0] sum_o
);
    always_comb begin
        sum_o = prop_i ^ bit_c_i;
    end
endmodule

// File: rtl/cla32_adder.sv
module cla32_adder #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int NGRP = WIDTH / GRP;

    logic [WIDTH-1:0] prop_d;
    logic [WIDTH-1:0] gen_d;
    logic [WIDTH-1:0] bit_c_d;
    logic [NGRP-1:0]  grp_p;
    logic [NGRP-1:0]  grp_g;
    logic [NGRP-1:0]  blk_c;
    logic [NGRP-1:0]  blk_cin;

    cla_pg_stage #(.WIDTH(WIDTH)) pg_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .prop_o (prop_d),
        .gen_o  (gen_d)
    );

    always_comb begin
        blk_cin = {blk_c[NGRP-2:0], cin_i};
    end

    for (genvar k = 0; k < NGRP; k++) begin : g_blk
        cla_block_unit #(.GRP(GRP)) blk_i (
            .prop_i  (prop_d[k*GRP +: GRP]),
            .gen_i   (gen_d[k*GRP +: GRP]),
            .cin_i   (blk_cin[k]),
            .grp_p_o (grp_p[k]),
            .grp_g_o (grp_g[k]),
            .bit_c_o (bit_c_d[k*GRP +: GRP])
        );
    end

    cla_group_unit #(.NGRP(NGRP)) grp_i (
        .grp_p_i (grp_p),
        .grp_g_i (grp_g),
        .cin_i   (cin_i),
        .blk_c_o (blk_c)
    );

    cla_sum_stage #(.WIDTH(WIDTH)) sum_i (
        .prop_i  (prop_d),
        .bit_c_i (bit_c_d),
        .sum_o   (sum_o)
    );

    always_comb begin
        cout_o = blk_c[NGRP-1];
    end
endmodule

// File: rtl/cla32_adder_chk.sv
module cla32_adder_chk #(
    parameter int WIDTH = 32,
    parameter int NGRP  = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [NGRP-1:0]  grp_p,
    input logic [NGRP-1:0]  grp_g,
    input logic [NGRP-1:0]  blk_c
);
    logic [WIDTH:0] ref_total;
    logic           c_in_grp;

    always_comb begin
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        AST_SUM_MATCH: assert (sum_o == ref_total[WIDTH-1:0]); // R1
        AST_COUT_MATCH: assert (cout_o == ref_total[WIDTH]); // R2
        for (int k = 0; k < NGRP; k++) begin
            c_in_grp = (k == 0) ? cin_i : blk_c[(k == 0) ? 0 : k - 1];
            AST_BOUNDARY_CARRY: assert (blk_c[k] == (grp_g[k] | (grp_p[k] & c_in_grp))); // R8
            AST_PG_EXCLUSIVE: assert (!(grp_p[k] && grp_g[k])); // R9
            AST_PASS_THROUGH: assert (!grp_p[k] || (blk_c[k] == c_in_grp)); // R9
        end
    end
endmodule

bind cla32_adder cla32_adder_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .grp_p  (grp_p),
    .grp_g  (grp_g),
    .blk_c  (blk_c)
);

// File: tb/cla32_adder_tb_top.sv
module cla32_adder_tb_top;
    logic        clk = 1'b0;
    logic [31:0] a_s = '0;
    logic [31:0] b_s = '0;
    logic        cin_s = 1'b0;
    logic [31:0] sum_w;
    logic        cout_w;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cla32_adder dut_i (
        .a_i    (a_s),
        .b_i    (b_s),
        .cin_i  (cin_s),
        .sum_o  (sum_w),
        .cout_o (cout_w)
    );

    function automatic logic [32:0] model_add(input logic [31:0] a, input logic [31:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {32'd0, c};
    endfunction

    // Nibble-wise model: each group sums its fields plus its own incoming carry.
    function automatic logic [31:0] model_nibbles(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [31:0] r;
        logic [4:0]  t;
        logic        cy;
        cy = c;
        for (int k = 0; k < 8; k++) begin
            t = {1'b0, a[k*4 +: 4]} + {1'b0, b[k*4 +: 4]} + {4'd0, cy};
            r[k*4 +: 4] = t[3:0];
            cy = t[4];
        end
        return r;
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c,
                         input string tag, input logic [31:0] exp_sum, input logic exp_cout);
        logic [32:0] m;
        @(negedge clk);
        a_s = a; b_s = b; cin_s = c;
        @(posedge clk);
        #1;
        m = model_add(a, b, c);
        check32({tag, " sum"}, sum_w, exp_sum);
        check32({tag, " cout"}, {31'd0, cout_w}, {31'd0, exp_cout});
        check32("R1 model sum", sum_w, m[31:0]);
        check32("R2 model cout", {31'd0, cout_w}, {31'd0, m[32]});
        check32("R8 group fields", sum_w, model_nibbles(a, b, c));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        apply(32'h0, 32'h0, 1'b0, "R3 zero", 32'h0, 1'b0);
        apply(32'hFFFFFFFF, 32'h1, 1'b0, "R4 ones plus one", 32'h0, 1'b1);
        apply(32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, "R5 chain cin1", 32'h0, 1'b1);
        apply(32'hF0F0F0F0, 32'h0F0F0F0F, 1'b0, "R5 chain cin0", 32'hFFFFFFFF, 1'b0);
        apply(32'hFFFFFFFF, 32'h0, 1'b1, "R5 ones cin1", 32'h0, 1'b1);
        apply(32'h0000000F, 32'hFFFFFFF1, 1'b0, "R6 low generate", 32'h0, 1'b1);
        apply(32'h12345678, 32'hEDCBA988, 1'b0, "R6 mixed chain", 32'h0, 1'b1);
        apply(32'hAAAAAAAA, 32'h55555555, 1'b0, "R7 alt cin0", 32'hFFFFFFFF, 1'b0);
        apply(32'hAAAAAAAA, 32'h55555555, 1'b1, "R7 alt cin1", 32'h0, 1'b1);
        apply(32'h000000F8, 32'h00000008, 1'b0, "R9 pass group1", 32'h00000100, 1'b0);
        apply(32'h0F0000F8, 32'h00000008, 1'b0, "R9 stop at kill", 32'h0F000100, 1'b0);
        apply(32'h80000000, 32'h80000000, 1'b0, "R2 top generate", 32'h0, 1'b1);
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            logic        rc;
            logic [32:0] m;
            ra = $urandom();
            rb = $urandom();
            rc = 1'($urandom());
            case (n % 4)
                0: rb = ~ra ^ (32'h1 << (n % 32));
                1: rb = ~ra;
                default: ;
            endcase
            m = model_add(ra, rb, rc);
            apply(ra, rb, rc, "R1 random", m[31:0], m[32]);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule